// File: doc/BRIEF.md
# CRC-32 Accumulator with Register Interface

This block is a bus slave that keeps a running 32-bit CRC over bytes written to it by a host processor. The CRC is the reflected Ethernet form: polynomial constant 0xEDB88320, shifting right, with the data bits taken least significant first. Software takes the block back to the seed value by writing to a clear register. It then feeds data through one of three feed registers and reads the raw accumulator back. No final complement is applied; software inverts the value itself if it needs to.

The host sees a simple single-cycle register port. A write is accepted on the clock edge at which the write enable is high. Read data is combinational from the current state, so it is valid in the same cycle as the read enable. Each feed register applies its own byte order to the same accumulator. A full word is folded in within one clock. Alongside the CRC sits a 32-bit general control/status register that software can read and write.

Top module: `crc32_pio_slave`

## Requirements
- R1: After the synchronous reset input `rst`, the accumulator reads 0xFFFFFFFF at byte offset 48, and the control register at offset 56 reads 0.
- R2: A write of any data to offset 8 loads the accumulator with 0xFFFFFFFF.
- R3: A write to offset 16 folds only `bus_wdata[7:0]` into the CRC. Each data bit, LSB first, shifts the CRC right by one and XORs in 0xEDB88320 when the old CRC bit 0 XOR the data bit is 1. From 0xFFFFFFFF, the bytes of ASCII "123456789" give 0x340BC6D9.
- R4: A write to offset 24 folds four bytes in this order: bits 31:24, 23:16, 15:8, 7:0.
- R5: A write to offset 32 folds four bytes in this order: bits 7:0, 15:8, 23:16, 31:24.
- R6: A write to offset 56 stores all 32 data bits, and a read at offset 56 returns them.
- R7: Writes to unmapped offsets, and to the read-only CRC offset 48, change neither the accumulator nor the control register.
- R8: Reads of offsets 8, 16, 24, 32 and of unmapped offsets return 0.
- R9: Address bits 1:0 are ignored. For example, a write to offset 19 acts as a write to offset 16.
- R10: `bus_rdata` is 0 whenever `bus_ren` is low.
- R11: A word fed in one cycle is fully folded in, so a read in the very next cycle returns the updated CRC.
- R12: Asserting `rst` in the middle of operation returns both registers to their R1 values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address; bits 1:0 are ignored |
| bus_wen | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe for this cycle |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |

## Verification
A corrupted accumulator cannot hide. The CRC register is readable directly, so any wrong bit shows on the very next read at offset 48, one cycle after the write that caused it. The checks read the accumulator right after every word feed. A wrong byte order or a wrong polynomial tap therefore shows at once as a mismatch against an independent bit-serial model. Mis-decoded addresses show as nonzero data from write-only offsets, or as unexpected changes to the CRC or control value after a write that should have been ignored.

// File: rtl/crc32_pio_pkg.sv
package crc32_pio_pkg;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

    // Byte offsets of the register window
    localparam int OFS_CLEAR    = 8;
    localparam int OFS_BYTE     = 16;
    localparam int OFS_WORD_MSB = 24;
    localparam int OFS_WORD_LSB = 32;
    localparam int OFS_CRC      = 48;
    localparam int OFS_CTRL     = 56;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CLEAR,
        ACC_BYTE,
        ACC_WMSB,
        ACC_WLSB,
        ACC_CRC,
        ACC_CTRL
    } acc_e;

endpackage

// File: rtl/crc32_byte_step.sv
module crc32_byte_step #(
    parameter int              CRC_W = 32,
    parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
    input  logic [CRC_W-1:0] crc_i,
    input  logic [7:0]       byte_i,
    output logic [CRC_W-1:0] crc_o
);

    localparam int BITS = 8;

    logic [CRC_W-1:0] stage [0:BITS];

    assign stage[0] = crc_i;

    // One reflected shift per data bit, LSB first
    for (genvar b = 0; b < BITS; b++) begin : g_bit
        assign stage[b+1] = (stage[b][0] ^ byte_i[b])
                          ? ((stage[b] >> 1) ^ POLY)
                          : (stage[b] >> 1);
    end

    assign crc_o = stage[BITS];

endmodule

// File: rtl/crc32_word_fold.sv
module crc32_word_fold #(
    parameter int               CRC_W     = 32,
    parameter logic [CRC_W-1:0] POLY      = 32'hEDB88320,
    parameter int               DATA_W    = 32,
    parameter bit               MSB_FIRST = 1'b1
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [CRC_W-1:0]  crc_o
);

    localparam int LANES = DATA_W / 8;

    logic [CRC_W-1:0] chain [0:LANES];
    assign chain[0] = crc_i;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int LANE_IDX = MSB_FIRST ? (LANES - 1 - k) : k;
        crc32_byte_step #(
            .CRC_W (CRC_W),
            .POLY  (POLY)
        ) step_i (
            .crc_i  (chain[k]),
            .byte_i (word_i[LANE_IDX*8 +: 8]),
            .crc_o  (chain[k+1])
        );
    end

    assign crc_o = chain[LANES];

endmodule

// File: rtl/crc32_addr_decode.sv
module crc32_addr_decode
    import crc32_pio_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output acc_e              kind_o
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] IDX_CLEAR = IDX_W'(OFS_CLEAR    >> 2);
    localparam logic [IDX_W-1:0] IDX_BYTE  = IDX_W'(OFS_BYTE     >> 2);
    localparam logic [IDX_W-1:0] IDX_WMSB  = IDX_W'(OFS_WORD_MSB >> 2);
    localparam logic [IDX_W-1:0] IDX_WLSB  = IDX_W'(OFS_WORD_LSB >> 2);
    localparam logic [IDX_W-1:0] IDX_CRC   = IDX_W'(OFS_CRC      >> 2);
    localparam logic [IDX_W-1:0] IDX_CTRL  = IDX_W'(OFS_CTRL     >> 2);

    logic [IDX_W-1:0] idx;
    logic             unused_low;

    assign idx        = addr_i[ADDR_W-1:2];
    assign unused_low = ^addr_i[1:0];

    always_comb begin
        kind_o = ACC_NONE;
        if      (idx == IDX_CLEAR) kind_o = ACC_CLEAR;
        else if (idx == IDX_BYTE)  kind_o = ACC_BYTE;
        else if (idx == IDX_WMSB)  kind_o = ACC_WMSB;
        else if (idx == IDX_WLSB)  kind_o = ACC_WLSB;
        else if (idx == IDX_CRC)   kind_o = ACC_CRC;
        else if (idx == IDX_CTRL)  kind_o = ACC_CTRL;
    end

endmodule

// File: rtl/crc32_pio_slave.sv
module crc32_pio_slave
    import crc32_pio_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ren,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int CRC_W = 32;

    typedef struct packed {
        logic [CRC_W-1:0]  crc;
        logic [DATA_W-1:0] ctrl;
    } state_t;

    state_t state_d, state_q;
    acc_e   kind;

    logic [CRC_W-1:0] crc_byte, crc_wmsb, crc_wlsb;

    crc32_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr_i (bus_addr),
        .kind_o (kind)
    );

    crc32_byte_step #(.CRC_W(CRC_W), .POLY(CRC_POLY)) byte_i (
        .crc_i  (state_q.crc),
        .byte_i (bus_wdata[7:0]),
        .crc_o  (crc_byte)
    );

    crc32_word_fold #(.CRC_W(CRC_W), .POLY(CRC_POLY), .DATA_W(DATA_W), .MSB_FIRST(1'b1)) wmsb_i (
        .crc_i  (state_q.crc),
        .word_i (bus_wdata),
        .crc_o  (crc_wmsb)
    );

    crc32_word_fold #(.CRC_W(CRC_W), .POLY(CRC_POLY), .DATA_W(DATA_W), .MSB_FIRST(1'b0)) wlsb_i (
        .crc_i  (state_q.crc),
        .word_i (bus_wdata),
        .crc_o  (crc_wlsb)
    );

    always_comb begin
        state_d = state_q;
        if (bus_wen) begin
            case (kind)
                ACC_CLEAR: state_d.crc  = CRC_SEED;
                ACC_BYTE:  state_d.crc  = crc_byte;
                ACC_WMSB:  state_d.crc  = crc_wmsb;
                ACC_WLSB:  state_d.crc  = crc_wlsb;
                ACC_CTRL:  state_d.ctrl = bus_wdata;
                default:   state_d      = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.crc  <= CRC_SEED;
            state_q.ctrl <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_ren) begin
            case (kind)
                ACC_CRC:  bus_rdata = DATA_W'(state_q.crc);
                ACC_CTRL: bus_rdata = state_q.ctrl;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R2: clear register reloads the seed
    a_r2_clear_seed: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && kind == ACC_CLEAR) |=> (state_q.crc == CRC_SEED));

    // R6: control write lands in the register
    a_r6_ctrl_store: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && kind == ACC_CTRL) |=> (state_q.ctrl == $past(bus_wdata)));

    // R7: ignored writes leave all state alone
    a_r7_ignored_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && (kind == ACC_NONE || kind == ACC_CRC))
        |=> ($stable(state_q.crc) && $stable(state_q.ctrl)));

    // R8: write-only and unmapped offsets read as zero
    a_r8_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_ren && kind != ACC_CRC && kind != ACC_CTRL) |-> (bus_rdata == '0));

    // R10: no read strobe, no data
    a_r10_idle_bus: assert property (@(posedge clk) disable iff (rst)
        !bus_ren |-> (bus_rdata == '0));

    // R7: accumulator holds without a write
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !bus_wen |=> $stable(state_q.crc));

endmodule

// File: tb/crc32_pio_slave_tb_top.sv
module crc32_pio_slave_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ren = 1'b0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] model_crc;

    always #2.5 clk = ~clk;

    crc32_pio_slave dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_ren   (bus_ren),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [31:0] ref_byte(logic [31:0] c, logic [7:0] d);
        logic [31:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if ((r[0] ^ d[i]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
            else                       r = r >> 1;
        end
        return r;
    endfunction

    // Monitor: compares each read against the scoreboard
    always @(negedge clk) begin
        if (bus_ren) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL unexpected read: actual %08h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %08h expected %08h", t, bus_rdata, e);
                end
            end
        end
    end

    // All tasks start and end just after a rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(posedge clk); #1;
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_addr = a; bus_ren = 1'b1;
        @(posedge clk); #1;
        bus_ren = 1'b0;
    endtask

    task automatic plain_check(input bit ok, input string t,
                               input logic [31:0] act, input logic [31:0] e);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", t, act, e);
        end
    endtask

    initial begin
        logic [31:0] w;
        logic [7:0]  msg [9];
        msg = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(8'd48, 32'hFFFFFFFF, "R1 crc after reset");
        rd(8'd56, 32'h0, "R1 ctrl after reset");

        // R3 model anchor and byte feed with junk upper bits
        model_crc = 32'hFFFFFFFF;
        foreach (msg[i]) model_crc = ref_byte(model_crc, msg[i]);
        plain_check(model_crc == 32'h340BC6D9, "R3 model anchor", model_crc, 32'h340BC6D9);
        model_crc = 32'hFFFFFFFF;
        foreach (msg[i]) begin
            wr(8'd16, {24'hA5C3E1, msg[i]});
            model_crc = ref_byte(model_crc, msg[i]);
        end
        rd(8'd48, 32'h340BC6D9, "R3 byte feed check value");

        // R2 clear with arbitrary data
        wr(8'd8, 32'h12345678);
        model_crc = 32'hFFFFFFFF;
        rd(8'd48, model_crc, "R2 clear register");

        // R4 MSB-first word, R11 read next cycle
        w = 32'hDEADBEEF;
        wr(8'd24, w);
        model_crc = ref_byte(model_crc, w[31:24]);
        model_crc = ref_byte(model_crc, w[23:16]);
        model_crc = ref_byte(model_crc, w[15:8]);
        model_crc = ref_byte(model_crc, w[7:0]);
        rd(8'd48, model_crc, "R4 R11 msb-first word");

        // R5 LSB-first word
        w = 32'h0155AAF0;
        wr(8'd32, w);
        model_crc = ref_byte(model_crc, w[7:0]);
        model_crc = ref_byte(model_crc, w[15:8]);
        model_crc = ref_byte(model_crc, w[23:16]);
        model_crc = ref_byte(model_crc, w[31:24]);
        rd(8'd48, model_crc, "R5 R11 lsb-first word");

        // R4 vs R5 equivalence on a known string
        wr(8'd8, 32'h0);
        wr(8'd24, 32'h31323334);
        wr(8'd32, 32'h38373635);
        wr(8'd16, 32'h00000039);
        rd(8'd48, 32'h340BC6D9, "R4 R5 mixed feed of check string");
        model_crc = 32'h340BC6D9;

        // R6 control register
        wr(8'd56, 32'hC0FFEE11);
        rd(8'd56, 32'hC0FFEE11, "R6 ctrl readback");

        // R7 ignored writes
        wr(8'd40, 32'hFFFFFFFF);
        wr(8'd48, 32'h00000000);
        wr(8'd0,  32'h55555555);
        rd(8'd48, model_crc, "R7 crc untouched");
        rd(8'd56, 32'hC0FFEE11, "R7 ctrl untouched");

        // R8 zero reads
        rd(8'd8,  32'h0, "R8 clear reg reads zero");
        rd(8'd16, 32'h0, "R8 byte reg reads zero");
        rd(8'd24, 32'h0, "R8 msb word reads zero");
        rd(8'd32, 32'h0, "R8 lsb word reads zero");
        rd(8'd40, 32'h0, "R8 unmapped reads zero");

        // R9 low address bits ignored
        wr(8'd19, 32'h0000007E);
        model_crc = ref_byte(model_crc, 8'h7E);
        rd(8'd50, model_crc, "R9 unaligned byte write and read");

        // R10 no strobe means zero
        bus_addr = 8'd48;
        #1;
        plain_check(bus_rdata == 32'h0, "R10 idle rdata", bus_rdata, 32'h0);
        @(posedge clk); #1;

        // R12 mid-run reset
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        rd(8'd48, 32'hFFFFFFFF, "R12 crc after mid reset");
        rd(8'd56, 32'h0, "R12 ctrl after mid reset");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule